// File: doc/BRIEF.md
# PCI Transmit Descriptor Fetch Master

This block is the initiator side of a network transmit path. When software or a controller wants the next transmit descriptor, it pulses `start`. The block asks for the bus, waits for the grant and issues one Memory Read burst to the descriptor base address. It then collects exactly four 32-bit descriptor words while honouring the target's wait states. After the last word has transferred, it releases the bus.

From the four words it extracts three values. The ownership flag comes from the most significant bit of the first word. The buffer length in dwords comes from the size field of the second word. The buffer start address is the third word. The fourth word is passed on unchanged. A one-clock `done` pulse marks new results. A companion `xfer_req` pulse asks the downstream data mover to start a buffer transfer, and it fires only when the device owns the descriptor. If no target claims the cycle in time, the block ends the cycle as a master abort and pulses `abort_err` in place of `done`.

The tristate AD and C/BE# lines are modelled as separate input, output and output-enable signals. The active-low control pins are driven high whenever the block is not using them.

Top module: `txdesc_fetch_master`

## Requirements
- R1: After a `start` pulse accepted while idle, `req_n` goes low on the next clock and stays low. FRAME# stays high until `gnt_n` has been sampled low. `req_n` remains low through the last data phase.
- R2: The clock after the grant is sampled is the address phase, which lasts exactly one clock. In it `frame_n`=0, `ad_oe`=1, `ad_out`=0x40000000 and `cbe_out`=4'b0110 (Memory Read), with `cbe_oe`=1.
- R3: The next clock is a turnaround. `ad_oe`=0 there and from then on, `frame_n`=0, `irdy_n`=0, and `cbe_oe`=1 with `cbe_out`=4'b0000 (all bytes enabled). No data is taken in this clock.
- R4: Exactly four data phases follow. `frame_n` is high during the fourth data phase and low in the earlier ones. `irdy_n` stays low until the fourth transfer. On the clock after it, `frame_n`, `irdy_n` and `req_n` are all 1, and `ad_oe` and `cbe_oe` are both 0.
- R5: A word is taken only at a clock edge where `devsel_n`=0 and `trdy_n`=0 while a data phase is in progress. A clock with `trdy_n`=1 inserts a wait state, and whatever is on `ad_in` during that clock is not captured.
- R6: `own` equals bit 31 of the first word received.
- R7: `buf_len` equals bits 10:0 of the second word divided by 4. For example, 0x040 gives 16 and 0x7FC gives 511.
- R8: `buf_addr` equals the third word and `tdes3` equals the fourth word, both unmodified.
- R9: `done` is a one-clock pulse in the clock after the fourth transfer. From that clock the four result outputs hold their values until the next successful fetch completes. An aborted fetch leaves them unchanged.
- R10: `xfer_req` pulses together with `done` when `own`=1, and stays 0 when `own`=0.
- R11: If `devsel_n` is not low at any of the five clock edges that follow the address phase, a master abort follows. In the next clock `frame_n`=1 and `irdy_n`=0. In the clock after that every bus output is released and `abort_err` pulses, and `done` does not fire. A DEVSEL# first seen at the fifth edge does not abort.
- R12: A `start` pulse while a fetch or its completion clock is in progress has no effect. No second request follows the current fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to launch one descriptor fetch |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Cycle frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| devsel_n | input | 1 | Target device select, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad_in | input | 32 | Address/data lines as driven by the target |
| ad_out | output | 32 | Address value driven in the address phase |
| ad_oe | output | 1 | Output enable for the address/data lines |
| cbe_out | output | 4 | Command, then byte enables (active low) |
| cbe_oe | output | 1 | Output enable for the command/byte-enable lines |
| done | output | 1 | One-clock pulse: a descriptor fetch completed |
| own | output | 1 | Ownership flag of the last fetched descriptor |
| buf_len | output | 9 | Buffer length in dwords |
| buf_addr | output | 32 | Transmit buffer start address |
| tdes3 | output | 32 | Fourth descriptor word, unmodified |
| xfer_req | output | 1 | One-clock pulse requesting the buffer transfer |
| abort_err | output | 1 | One-clock pulse: master abort, no target answered |

## Verification
The assertions rely on a well-behaved target. Once the target asserts DEVSEL# it holds it low until the cycle ends. It never asserts TRDY# without DEVSEL#. It never asserts DEVSEL# outside a cycle the block has framed. The bench's target responder follows these rules by construction: it derives DEVSEL# from a clock count that starts at the address phase and holds it for the rest of the cycle. It drives TRDY# only during data phases in which DEVSEL# is already low, and it presents filler data on the AD lines during every wait state.

// File: rtl/txdesc_pkg.sv
// Shared types and constants for the transmit descriptor fetch master.
// Assumes a 32-bit bus and a fixed four-word descriptor.
package txdesc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_TURN,
        ST_DATA,
        ST_DONE,
        ST_ABORT,
        ST_ERR
    } fetch_st_t;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;
    localparam logic [3:0] BE_ALL       = 4'b0000;
    localparam int         DESC_WORDS   = 4;
    localparam int         IDX_W        = $clog2(DESC_WORDS);

endpackage

// File: rtl/txdesc_bus_fsm.sv
// Bus sequencer: request, address phase, turnaround, four data phases,
// then release; a missing DEVSEL# within TMO_CLKS edges gives a master abort.
// Assumes the target holds DEVSEL# once asserted and only drives TRDY# with it.
module txdesc_bus_fsm
    import txdesc_pkg::*;
#(
    parameter logic [31:0] DESC_BASE = 32'h4000_0000,
    parameter int          TMO_CLKS  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             gnt_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    output logic             req_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [31:0]      ad_out,
    output logic             ad_oe,
    output logic [3:0]       cbe_out,
    output logic             cbe_oe,
    output logic             beat,
    output logic [IDX_W-1:0] beat_idx,
    output logic             fetch_done,
    output logic             abort_err
);
    localparam int WCNT_W = $clog2(TMO_CLKS + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DESC_WORDS - 1);
    localparam logic [WCNT_W-1:0] TMO_LAST = WCNT_W'(TMO_CLKS - 1);

    fetch_st_t         state, state_nx;
    logic [WCNT_W-1:0] wcnt;
    logic              seen;
    logic              in_cycle;

    assign in_cycle = (state == ST_TURN) || (state == ST_DATA);
    assign beat     = (state == ST_DATA) && !devsel_n && !trdy_n;

    // Next-state selection for the bus sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start) state_nx = ST_REQ;
            ST_REQ:   if (!gnt_n) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_TURN;
            ST_TURN:  state_nx = ST_DATA;
            ST_DATA: begin
                if (beat && beat_idx == LAST_IDX)
                    state_nx = ST_DONE;
                else if (!seen && devsel_n && wcnt == TMO_LAST)
                    state_nx = ST_ABORT;
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_ABORT: state_nx = ST_ERR;
            ST_ERR:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // DEVSEL# watch: clock count since the address phase and a seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_ADDR) begin
            wcnt <= '0;
            seen <= 1'b0;
        end else if (in_cycle) begin
            if (!devsel_n)  seen <= 1'b1;
            else if (!seen) wcnt <= wcnt + 1'b1;
        end
    end

    // Data phase index, advanced on each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_ADDR) beat_idx <= '0;
        else if (beat && beat_idx != LAST_IDX) beat_idx <= beat_idx + 1'b1;
    end

    // Bus pin drive decoded from the sequence position.
    always_comb begin
        req_n      = !(state inside {ST_REQ, ST_ADDR, ST_TURN, ST_DATA});
        frame_n    = !((state == ST_ADDR) || (state == ST_TURN) ||
                       (state == ST_DATA && beat_idx != LAST_IDX));
        irdy_n     = !(state inside {ST_TURN, ST_DATA, ST_ABORT});
        ad_oe      = (state == ST_ADDR);
        ad_out     = (state == ST_ADDR) ? DESC_BASE : 32'h0;
        cbe_oe     = state inside {ST_ADDR, ST_TURN, ST_DATA, ST_ABORT};
        cbe_out    = (state == ST_ADDR) ? CMD_MEM_READ : BE_ALL;
        fetch_done = (state == ST_DONE);
        abort_err  = (state == ST_ERR);
    end

    a_r1_frame_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (!$past(gnt_n) && !$past(req_n)));

    a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (ad_oe && ad_out == DESC_BASE && cbe_out == CMD_MEM_READ));

    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> (!ad_oe && !frame_n && !irdy_n));

    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && trdy_n && seen) |=> (state == ST_DATA && $stable(beat_idx)));

    a_r4_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && !irdy_n && !trdy_n && !devsel_n) |=> (irdy_n && req_n && !cbe_oe));

endmodule

// File: rtl/txdesc_decode.sv
// Descriptor capture and decode: stages words as they transfer and updates
// the result registers on the final transfer only.
// Assumes beat and beat_idx come from the bus sequencer in transfer order.
module txdesc_decode
    import txdesc_pkg::*;
#(
    parameter int SIZE_W = 11,
    localparam int LEN_W = SIZE_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic [31:0]      ad_in,
    output logic             own,
    output logic [LEN_W-1:0] buf_len,
    output logic [31:0]      buf_addr,
    output logic [31:0]      tdes3
);
    logic              st_own;
    logic [LEN_W-1:0]  st_len;
    logic [31:0]       st_addr;
    logic              last_beat;

    assign last_beat = beat && (beat_idx == IDX_W'(DESC_WORDS - 1));

    // Staging of the first three words as each one transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_own  <= 1'b0;
            st_len  <= '0;
            st_addr <= '0;
        end else if (beat) begin
            case (beat_idx)
                IDX_W'(0): st_own  <= ad_in[31];
                IDX_W'(1): st_len  <= ad_in[SIZE_W-1:2];
                IDX_W'(2): st_addr <= ad_in;
                default:   ;
            endcase
        end
    end

    // Result registers, committed only when the whole descriptor has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own      <= 1'b0;
            buf_len  <= '0;
            buf_addr <= '0;
            tdes3    <= '0;
        end else if (last_beat) begin
            own      <= st_own;
            buf_len  <= st_len;
            buf_addr <= st_addr;
            tdes3    <= ad_in;
        end
    end

    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last_beat |=> ($stable(own) && $stable(buf_len) && $stable(buf_addr) && $stable(tdes3)));

endmodule

// File: rtl/txdesc_fetch_master.sv
// Top of the transmit descriptor fetch master: one burst read of a four-word
// descriptor, decoded into ownership, length and address results.
// Assumes a 32-bit initiator read; pins are split into in/out/enable.
module txdesc_fetch_master
    import txdesc_pkg::*;
#(
    parameter logic [31:0] DESC_BASE = 32'h4000_0000,
    parameter int          TMO_CLKS  = 5,
    parameter int          SIZE_W    = 11,
    localparam int         LEN_W     = SIZE_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req_n,
    input  logic             gnt_n,
    output logic             frame_n,
    output logic             irdy_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic [31:0]      ad_in,
    output logic [31:0]      ad_out,
    output logic             ad_oe,
    output logic [3:0]       cbe_out,
    output logic             cbe_oe,
    output logic             done,
    output logic             own,
    output logic [LEN_W-1:0] buf_len,
    output logic [31:0]      buf_addr,
    output logic [31:0]      tdes3,
    output logic             xfer_req,
    output logic             abort_err
);
    logic             beat;
    logic [IDX_W-1:0] beat_idx;

    txdesc_bus_fsm #(
        .DESC_BASE (DESC_BASE),
        .TMO_CLKS  (TMO_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gnt_n      (gnt_n),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .req_n      (req_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .cbe_out    (cbe_out),
        .cbe_oe     (cbe_oe),
        .beat       (beat),
        .beat_idx   (beat_idx),
        .fetch_done (done),
        .abort_err  (abort_err)
    );

    txdesc_decode #(
        .SIZE_W (SIZE_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .beat_idx (beat_idx),
        .ad_in    (ad_in),
        .own      (own),
        .buf_len  (buf_len),
        .buf_addr (buf_addr),
        .tdes3    (tdes3)
    );

    // Buffer transfer launch, gated by the ownership flag.
    assign xfer_req = done && own;

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat && beat_idx == IDX_W'(DESC_WORDS - 1)));

    a_r11_abort_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> (!done && $past(frame_n && !irdy_n && req_n)));

    a_r10_req_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (done && $past(frame_n)));

endmodule

// File: tb/txdesc_fetch_master_tb.sv
module txdesc_fetch_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1;
    logic [31:0] ad_in = 32'h0;
    logic        req_n, frame_n, irdy_n, ad_oe, cbe_oe, done, own, xfer_req, abort_err;
    logic [31:0] ad_out, buf_addr, tdes3;
    logic [3:0]  cbe_out;
    logic [8:0]  buf_len;

    always #5 clk = ~clk;

    txdesc_fetch_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_n(req_n), .gnt_n(gnt_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out),
        .cbe_oe(cbe_oe), .done(done), .own(own), .buf_len(buf_len),
        .buf_addr(buf_addr), .tdes3(tdes3), .xfer_req(xfer_req), .abort_err(abort_err)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Target responder configuration
    int          gnt_delay = 0, devsel_delay = 1;
    int          stall [4];
    logic [31:0] words [4];
    // Target responder state
    int req_clks = 0, tclk = 0, tbeat = 0, swait = 0;
    bit intx = 0, pend = 0;

    // Behavioural reference model: phase 0 idle, 1 request, 2 address,
    // 3 turnaround, 4 data, 5 done, 6 abort, 7 error
    int          ph = 0, mb = 0, mw_clk = 0;
    bit          mseen = 0;
    logic [31:0] mw [4];
    logic        e_own = 0;
    logic [8:0]  e_len = 0;
    logic [31:0] e_addr = 0, e_t3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; mb = 0; mw_clk = 0; mseen = 0;
        end else begin
            case (ph)
                0: if (start) ph = 1;
                1: if (!gnt_n) ph = 2;
                2: begin ph = 3; mb = 0; mw_clk = 0; mseen = 0; end
                3: begin
                    if (!devsel_n) mseen = 1; else mw_clk++;
                    ph = 4;
                end
                4: begin
                    if (!devsel_n && !trdy_n) begin
                        mw[mb] = ad_in;
                        if (mb == 3) begin
                            ph = 5;
                            e_own = mw[0][31];
                            e_len = 9'(mw[1][10:0] >> 2);
                            e_addr = mw[2];
                            e_t3 = mw[3];
                        end else mb++;
                    end else if (!mseen && devsel_n && mw_clk == 4) ph = 6;
                    if (!devsel_n) mseen = 1;
                    else if (!mseen) mw_clk++;
                end
                5: ph = 0;
                6: ph = 7;
                7: ph = 0;
                default: ph = 0;
            endcase
        end
    end

    // Negedge: compare outputs with the model, then drive the target side.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 req_n", req_n, (ph >= 1 && ph <= 4) ? 0 : 1);
            chk("R4 frame_n", frame_n, (ph == 2 || ph == 3 || (ph == 4 && mb < 3)) ? 0 : 1);
            chk("R4 irdy_n", irdy_n, (ph == 3 || ph == 4 || ph == 6) ? 0 : 1);
            chk("R2 ad_oe", ad_oe, (ph == 2) ? 1 : 0);
            if (ph == 2) chk("R2 ad_out", ad_out, 32'h4000_0000);
            chk("R3 cbe_oe", cbe_oe, (ph >= 2 && ph <= 4) || ph == 6 ? 1 : 0);
            if (ph == 2) chk("R2 cbe_out", cbe_out, 4'b0110);
            if (ph == 3 || ph == 4) chk("R3 cbe_out", cbe_out, 4'b0000);
            chk("R9 done", done, (ph == 5) ? 1 : 0);
            chk("R11 abort_err", abort_err, (ph == 7) ? 1 : 0);
            chk("R10 xfer_req", xfer_req, (ph == 5 && e_own) ? 1 : 0);
            chk("R6 own", own, e_own);
            chk("R7 buf_len", buf_len, e_len);
            chk("R8 buf_addr", buf_addr, e_addr);
            chk("R8 tdes3", tdes3, e_t3);
        end
        if (!rst_n) begin
            gnt_n = 1; devsel_n = 1; trdy_n = 1; ad_in = 32'hDEAD_BEEF;
            req_clks = 0; intx = 0; pend = 0; tclk = 0; tbeat = 0; swait = 0;
        end else begin
            if (pend) begin tbeat++; swait = 0; pend = 0; end
            if (!req_n) begin gnt_n = (req_clks < gnt_delay); req_clks++; end
            else begin gnt_n = 1; req_clks = 0; end
            if (!frame_n && ad_oe) begin
                intx = 1; tclk = 0; tbeat = 0; swait = 0;
            end else if (intx) begin
                if (frame_n && irdy_n) intx = 0; else tclk++;
            end
            devsel_n = !(intx && tclk >= devsel_delay);
            if (intx && tclk >= 2 && !devsel_n && tbeat < 4) begin
                if (swait < stall[tbeat]) begin
                    trdy_n = 1; swait++; ad_in = 32'hDEAD_BEEF;
                end else begin
                    trdy_n = 0; ad_in = words[tbeat];
                end
            end else begin
                trdy_n = 1; ad_in = 32'hDEAD_BEEF;
            end
            pend = !irdy_n && !trdy_n && !devsel_n;
        end
    end

    // One fetch with a given target behaviour; checks the result fields.
    task automatic run_fetch(input logic [31:0] w0, w1, w2, w3,
                             input int gd, dd, s0, s1, s2, s3,
                             input bit exp_abort, input int busy_at);
        bit got_done = 0, got_abort = 0;
        logic [31:0] old_addr;
        old_addr = buf_addr;
        @(negedge clk);
        words[0] = w0; words[1] = w1; words[2] = w2; words[3] = w3;
        stall[0] = s0; stall[1] = s1; stall[2] = s2; stall[3] = s3;
        gnt_delay = gd; devsel_delay = dd;
        start = 1;
        @(negedge clk);
        start = 0;
        if (busy_at > 0) begin
            repeat (busy_at) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        for (int i = 0; i < 300; i++) begin
            if (done) begin got_done = 1; break; end
            if (abort_err) begin got_abort = 1; break; end
            @(negedge clk);
        end
        if (exp_abort) begin
            chk("R11 abort seen", 32'(got_abort), 1);
            chk("R11 no done", 32'(got_done), 0);
            chk("R9 addr kept after abort", buf_addr, old_addr);
        end else begin
            chk("R9 done seen", 32'(got_done), 1);
            chk("R6 own bit", 32'(own), 32'(w0[31]));
            chk("R7 length", 32'(buf_len), w1[10:0] >> 2);
            chk("R8 address", buf_addr, w2);
            chk("R8 word3", tdes3, w3);
            chk("R10 request", 32'(xfer_req), 32'(w0[31]));
        end
        repeat (4) @(negedge clk);
        chk("R12 no new request", 32'(req_n), 1);
        if (!exp_abort) chk("R9 held", buf_addr, w2);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin stall[i] = 0; words[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 reset req_n", 32'(req_n), 1);
        chk("R4 reset frame_n", 32'(frame_n), 1);
        chk("R2 reset ad_oe", 32'(ad_oe), 0);
        chk("R9 reset done", 32'(done), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R6 R7 R8: owned descriptor, 64-byte buffer, no waits
        run_fetch(32'h8000_0000, 32'h6200_0040, 32'hA000_0000, 32'h1234_5678, 0, 1, 0, 0, 0, 0, 0, 0);
        // R5 R10: not owned, wait states, delayed grant and DEVSEL#
        run_fetch(32'h7FFF_FFFF, 32'h0000_07FC, 32'h0BAD_F00C, 32'hCAFE_0001, 3, 2, 2, 0, 3, 1, 0, 0);
        // R12: extra start pulse while busy
        run_fetch(32'hC000_0001, 32'h0000_0100, 32'h1000_2000, 32'h5555_AAAA, 1, 1, 0, 1, 0, 2, 0, 3);
        // R11 boundary: DEVSEL# at the fifth edge, no abort
        run_fetch(32'h8000_00FF, 32'hFFFF_F804, 32'h2222_0000, 32'h0000_0000, 0, 5, 0, 0, 0, 4, 0, 0);
        // R11: DEVSEL# one edge late, and never
        run_fetch(32'h8000_0000, 32'h0000_0040, 32'h3333_0000, 32'h1, 0, 6, 0, 0, 0, 0, 1, 0);
        run_fetch(32'h8000_0000, 32'h0000_0040, 32'h4444_0000, 32'h2, 2, 99, 0, 0, 0, 0, 1, 0);
        // Recovery after abort
        run_fetch(32'hFFFF_FFFF, 32'h0000_0004, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 0, 3, 1, 1, 1, 1, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule